// File: doc/BRIEF.md
# Permuted-Diagonal Row Accumulator

This block lives inside one processing element of a sparse fully-connected layer engine. The weight matrix is built from square sub-matrices that each hold exactly one non-zero per row and per column. Each multiplier lane owns one sub-matrix row band and one bank of accumulators. Every cycle, each lane is handed a product, and the block works out which row of its sub-matrix that product belongs to. No row index is stored. The row is the lane's permutation value plus the column offset, reduced modulo the block size p. The product is then added into that row's accumulator.

The modulo uses one adder, one compare against p and one conditional subtract. Both operands are below p, so their sum is always below 2p, and no divider is needed. A start-of-vector pulse clears every accumulator. A drain pulse then reads the banks out one row per cycle, with an optional rectifier applied to each value on the way out.

Top module: `pd_accum_sel`

## Requirements
- R1: While `in_valid` is high and no drain is running, lane m adds its product (`prod_flat[m*32 +: 32]`) into entry (perm + col_off) mod p of bank m. Here perm is `perm_word[m*4 +: 4]` and p is `p_size`. No other entry of that bank changes.
- R2: Every block size p from 1 to 16 is supported, including sizes that are not powers of two. The caller keeps perm and col_off below p.
- R3: Each addition saturates to the signed 24-bit range, clamping at 8388607 on overflow and at -8388608 on underflow.
- R4: A `clear` pulse zeroes every accumulator. When `clear` and `in_valid` are high in the same cycle, the clear takes effect first, so the target entry ends up holding only that cycle's product.
- R5: A `drain` pulse sampled at clock edge E raises `out_valid` after edges E+1 through E+p, with `out_row` stepping 0, 1, …, p-1. Lane m's value for that row sits at `out_data[m*24 +: 24]`. Draining leaves the accumulators unchanged.
- R6: With `relu_en` high during a drain, negative accumulator values come out as 0. With `relu_en` low, values come out unchanged.
- R7: While a drain is running, `in_valid`, `clear` and `drain` are ignored, so a later drain shows the same contents.
- R8: After reset, `out_valid` is low and every accumulator reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Start-of-vector pulse that zeroes all accumulators |
| in_valid | input | 1 | Products for the current column are present |
| col_off | input | 4 | Column offset inside the current sub-matrix, below p |
| p_size | input | 5 | Block size p, 1 to 16 |
| perm_word | input | 32 | One 4-bit permutation value per lane |
| prod_flat | input | 256 | One signed 32-bit product per lane |
| drain | input | 1 | Starts the row-by-row read-out |
| relu_en | input | 1 | Applies the rectifier on read-out |
| busy | output | 1 | A drain is in progress |
| out_valid | output | 1 | `out_row` and `out_data` are valid |
| out_row | output | 4 | Row index being read out |
| out_data | output | 192 | One signed 24-bit value per lane for `out_row` |

## Verification
Two things can land in the same cycle: the start-of-vector clear and the first column's accumulation. The bench provokes this by raising `clear` together with `in_valid` on the opening column of every random vector. It judges the outcome by whether the drained row holds exactly that column's product and no older contribution. The second collision is accumulation or clear arriving while a drain is running. Here the bench injects large products and a clear in the middle of a read-out, then drains again and expects identical contents.

// File: rtl/pd_pkg.sv
package pd_pkg;
    parameter int unsigned PD_LANES  = 8;
    parameter int unsigned PD_DEPTH  = 16;
    parameter int unsigned PD_ACC_W  = 24;
    parameter int unsigned PD_PROD_W = 32;

    typedef enum logic {
        ACT_PASS = 1'b0,
        ACT_RELU = 1'b1
    } act_mode_e;
endpackage

// File: rtl/pd_row_mod.sv
module pd_row_mod #(
    parameter int unsigned PW = 4
) (
    input  logic [PW-1:0] perm,
    input  logic [PW-1:0] col,
    input  logic [PW:0]   p_size,
    output logic [PW-1:0] row
);
    logic [PW:0] sum;
    logic [PW:0] diff;
    logic        wrap;

    always_comb begin
        sum  = {1'b0, perm} + {1'b0, col};
        wrap = (sum >= p_size);
        diff = sum - p_size;
        row  = wrap ? diff[PW-1:0] : sum[PW-1:0];
    end
endmodule

// File: rtl/pd_sat_add.sv
module pd_sat_add #(
    parameter int unsigned ACC_W  = 24,
    parameter int unsigned PROD_W = 32
) (
    input  logic [ACC_W-1:0]  acc,
    input  logic [PROD_W-1:0] prod,
    output logic [ACC_W-1:0]  sum
);
    localparam int unsigned WW = PROD_W + 1;
    localparam logic signed [WW-1:0] MAXV = WW'((64'sd1 <<< (ACC_W - 1)) - 64'sd1);
    localparam logic signed [WW-1:0] MINV = -MAXV - WW'(1);

    logic signed [WW-1:0] wide;

    always_comb begin
        wide = $signed({{(WW-ACC_W){acc[ACC_W-1]}}, acc}) +
               $signed({prod[PROD_W-1], prod});
        if (wide > MAXV)      sum = MAXV[ACC_W-1:0];
        else if (wide < MINV) sum = MINV[ACC_W-1:0];
        else                  sum = wide[ACC_W-1:0];
    end
endmodule

// File: rtl/pd_act.sv
module pd_act
    import pd_pkg::*;
#(
    parameter int unsigned ACC_W = 24
) (
    input  act_mode_e        mode,
    input  logic [ACC_W-1:0] din,
    output logic [ACC_W-1:0] dout
);
    always_comb begin
        if (mode == ACT_RELU && din[ACC_W-1]) dout = '0;
        else                                  dout = din;
    end
endmodule

// File: rtl/pd_accum_sel.sv
module pd_accum_sel
    import pd_pkg::*;
#(
    parameter int unsigned NLANE  = PD_LANES,
    parameter int unsigned DEPTH  = PD_DEPTH,
    parameter int unsigned ACC_W  = PD_ACC_W,
    parameter int unsigned PROD_W = PD_PROD_W,
    localparam int unsigned PW    = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    in_valid,
    input  logic [PW-1:0]           col_off,
    input  logic [PW:0]             p_size,
    input  logic [NLANE*PW-1:0]     perm_word,
    input  logic [NLANE*PROD_W-1:0] prod_flat,
    input  logic                    drain,
    input  logic                    relu_en,
    output logic                    busy,
    output logic                    out_valid,
    output logic [PW-1:0]           out_row,
    output logic [NLANE*ACC_W-1:0]  out_data
);
    typedef struct packed {
        logic [NLANE-1:0][DEPTH-1:0][ACC_W-1:0] acc;
        logic                                   draining;
        logic [PW-1:0]                          cnt;
        logic                                   out_valid;
        logic [PW-1:0]                          out_row;
        logic [NLANE-1:0][ACC_W-1:0]            out_data;
    } state_t;

    state_t st_d, st_q;

    logic [NLANE-1:0][PW-1:0]    lane_row;
    logic [NLANE-1:0][ACC_W-1:0] lane_sum;
    logic [NLANE-1:0][ACC_W-1:0] rd_act;
    act_mode_e                   act_mode;

    assign act_mode = relu_en ? ACT_RELU : ACT_PASS;

    for (genvar m = 0; m < NLANE; m++) begin : g_lane
        logic [ACC_W-1:0] sel_acc;
        logic [ACC_W-1:0] base;

        pd_row_mod #(.PW(PW)) u_mod (
            .perm   (perm_word[m*PW +: PW]),
            .col    (col_off),
            .p_size (p_size),
            .row    (lane_row[m])
        );

        assign sel_acc = st_q.acc[m][lane_row[m]];
        assign base    = clear ? '0 : sel_acc;

        pd_sat_add #(.ACC_W(ACC_W), .PROD_W(PROD_W)) u_add (
            .acc  (base),
            .prod (prod_flat[m*PROD_W +: PROD_W]),
            .sum  (lane_sum[m])
        );

        pd_act #(.ACC_W(ACC_W)) u_act (
            .mode (act_mode),
            .din  (st_q.acc[m][st_q.cnt]),
            .dout (rd_act[m])
        );
    end

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        if (st_q.draining) begin
            st_d.out_valid = 1'b1;
            st_d.out_row   = st_q.cnt;
            st_d.out_data  = rd_act;
            if ({1'b0, st_q.cnt} == p_size - (PW+1)'(1)) begin
                st_d.draining = 1'b0;
                st_d.cnt      = '0;
            end else begin
                st_d.cnt = st_q.cnt + PW'(1);
            end
        end else begin
            if (clear) st_d.acc = '0;
            if (in_valid) begin
                for (int m = 0; m < NLANE; m++) begin
                    st_d.acc[m][lane_row[m]] = lane_sum[m];
                end
            end
            if (drain) begin
                st_d.draining = 1'b1;
                st_d.cnt      = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.draining;
    assign out_valid = st_q.out_valid;
    assign out_row   = st_q.out_row;
    assign out_data  = st_q.out_data;
endmodule

// File: rtl/pd_accum_sel_chk.sv
module pd_accum_sel_chk #(
    parameter int unsigned NLANE = 8,
    parameter int unsigned ACC_W = 24,
    parameter int unsigned PW    = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   busy,
    input logic [PW:0]            p_size,
    input logic [NLANE*PW-1:0]    lane_row,
    input logic                   relu_en,
    input logic                   out_valid,
    input logic [PW-1:0]          out_row,
    input logic [NLANE*ACC_W-1:0] out_data
);
    logic row_bad;
    logic neg_seen;

    always_comb begin
        row_bad  = 1'b0;
        neg_seen = 1'b0;
        for (int m = 0; m < NLANE; m++) begin
            if ({1'b0, lane_row[m*PW +: PW]} >= p_size) row_bad = 1'b1;
            if (out_data[m*ACC_W + ACC_W - 1])          neg_seen = 1'b1;
        end
    end

    // R1 / R2: every lane target lies inside the sub-matrix
    p_row_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy && p_size != '0) |-> !row_bad);

    // R5: read-out starts at row zero
    p_drain_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_row == '0));

    // R5: rows step by one until the last row of the block
    p_drain_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ({1'b0, out_row} != p_size - (PW+1)'(1))) |=>
        (out_valid && out_row == PW'($past(out_row) + 1'b1)));

    // R6: rectified read-out carries no negative value
    p_relu_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(relu_en)) |-> !neg_seen);
endmodule

bind pd_accum_sel pd_accum_sel_chk #(
    .NLANE (NLANE),
    .ACC_W (ACC_W),
    .PW    (PW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .busy      (busy),
    .p_size    (p_size),
    .lane_row  (lane_row),
    .relu_en   (relu_en),
    .out_valid (out_valid),
    .out_row   (out_row),
    .out_data  (out_data)
);

// File: tb/pd_accum_sel_test.sv
module pd_accum_sel_test;
    localparam int CLK_PERIOD = 10;
    localparam int NL  = 8;
    localparam int DP  = 16;
    localparam int AW  = 24;
    localparam int PRW = 32;
    localparam int PW  = 4;
    localparam longint AMAX = 64'sd8388607;
    localparam longint AMIN = -64'sd8388608;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear = 1'b0, in_valid = 1'b0, drain = 1'b0, relu_en = 1'b0;
    logic [PW-1:0]      col_off = '0;
    logic [PW:0]        p_size = 5'd16;
    logic [NL*PW-1:0]   perm_word = '0;
    logic [NL*PRW-1:0]  prod_flat = '0;
    logic               busy, out_valid;
    logic [PW-1:0]      out_row;
    logic [NL*AW-1:0]   out_data;

    int     n_run = 0, n_fail = 0;
    bit     done = 0;
    longint model [NL][DP];
    int     perm_v [NL];
    longint prod_v [NL];

    always #(CLK_PERIOD/2) clk = ~clk;

    pd_accum_sel uut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
        .col_off(col_off), .p_size(p_size), .perm_word(perm_word),
        .prod_flat(prod_flat), .drain(drain), .relu_en(relu_en),
        .busy(busy), .out_valid(out_valid), .out_row(out_row), .out_data(out_data)
    );

    function automatic longint clamp(longint v);
        if (v > AMAX) return AMAX;
        if (v < AMIN) return AMIN;
        return v;
    endfunction

    function automatic longint act(longint v, bit r);
        return (r && v < 0) ? 0 : v;
    endfunction

    task automatic check(string tag, bit ok, longint act_v, longint exp_v);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
        end
    endtask

    task automatic set_perms(int p, bit natural);
        for (int m = 0; m < NL; m++) begin
            perm_v[m] = natural ? (m % p) : int'($urandom_range(0, p - 1));
            perm_word[m*PW +: PW] = PW'(perm_v[m]);
        end
    endtask

    task automatic push(int c, bit clr, longint lo, longint hi);
        @(negedge clk);
        for (int m = 0; m < NL; m++) begin
            prod_v[m] = lo + longint'($urandom_range(0, 32'(hi - lo)));
            prod_flat[m*PRW +: PRW] = PRW'(prod_v[m]);
        end
        col_off = PW'(c); clear = clr; in_valid = 1'b1;
        if (clr) for (int m = 0; m < NL; m++) for (int r = 0; r < DP; r++) model[m][r] = 0;
        for (int m = 0; m < NL; m++) begin
            int r = (perm_v[m] + c) % int'(p_size);
            model[m][r] = clamp(model[m][r] + prod_v[m]);
        end
        @(negedge clk);
        in_valid = 1'b0; clear = 1'b0;
    endtask

    task automatic drain_check(string tag, bit r, bit disturb);
        int p = int'(p_size);
        @(negedge clk);
        drain = 1'b1; relu_en = r;
        @(negedge clk);
        drain = 1'b0;
        for (int i = 0; i < p; i++) begin
            @(negedge clk);
            if (disturb && i == 0) begin
                in_valid = 1'b1; clear = 1'b1; drain = 1'b1;
                prod_flat = {NL{32'sd300000}};
            end else begin
                in_valid = 1'b0; clear = 1'b0; drain = 1'b0;
            end
            check({tag, " R5 out_valid"}, out_valid === 1'b1, longint'(out_valid), 1);
            check({tag, " R5 out_row"}, out_row === PW'(i), longint'(out_row), i);
            for (int m = 0; m < NL; m++) begin
                longint e = act(model[m][i], r);
                longint a = longint'($signed(out_data[m*AW +: AW]));
                if (a != e) check({tag, " R1 data"}, 1'b0, a, e);
            end
            check({tag, " R1 row data"}, 1'b1, 0, 0);
        end
        @(negedge clk);
        in_valid = 1'b0; clear = 1'b0; drain = 1'b0;
        check({tag, " R5 end"}, out_valid === 1'b0, longint'(out_valid), 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int m = 0; m < NL; m++) for (int r = 0; r < DP; r++) model[m][r] = 0;
        repeat (3) @(negedge clk);
        check("R8 out_valid reset", out_valid === 1'b0, longint'(out_valid), 0);
        rst_n = 1'b1;
        p_size = 5'd16;
        drain_check("R8 zero after reset", 1'b0, 1'b0);

        // R1: natural permutation, p=4
        p_size = 5'd4; set_perms(4, 1'b1);
        for (int c = 0; c < 4; c++) push(c, c == 0, -500, 500);
        drain_check("R1 natural p4", 1'b0, 1'b0);

        // R2: extreme and odd block sizes
        p_size = 5'd1; set_perms(1, 1'b0);
        push(0, 1'b1, -100, 100); push(0, 1'b0, -100, 100);
        drain_check("R2 p1", 1'b0, 1'b0);
        p_size = 5'd16; set_perms(16, 1'b0);
        for (int c = 0; c < 16; c++) push(15 - c, c == 0, -1000, 1000);
        drain_check("R2 p16", 1'b0, 1'b0);
        p_size = 5'd5; set_perms(5, 1'b0);
        for (int c = 0; c < 10; c++) push(c % 5, c == 0, -1000, 1000);
        drain_check("R2 p5", 1'b0, 1'b0);

        // R4 / R6: random vectors, clear together with first column
        for (int v = 0; v < 8; v++) begin
            int p = int'($urandom_range(1, 16));
            p_size = 5'(p); set_perms(p, 1'b0);
            for (int k = 0; k < 3 * p; k++)
                push(int'($urandom_range(0, p - 1)), k == 0, -2000, 2000);
            drain_check("R4 R6 random", v[0], 1'b0);
        end

        // R4: clear same cycle as accumulate keeps only that product
        p_size = 5'd3; set_perms(3, 1'b1);
        push(1, 1'b0, 5000, 6000);
        push(1, 1'b1, -50, 50);
        drain_check("R4 clear+acc", 1'b0, 1'b0);

        // R3: saturation both ways
        p_size = 5'd2; set_perms(2, 1'b0);
        push(0, 1'b1, 1000000000, 1000000100);
        push(0, 1'b0, 1000000000, 1000000100);
        drain_check("R3 sat high", 1'b0, 1'b0);
        push(0, 1'b0, -1000000100, -1000000000);
        push(1, 1'b0, -1000000100, -1000000000);
        drain_check("R3 sat low", 1'b0, 1'b0);

        // R6: same negative contents with and without rectifier
        drain_check("R6 relu on", 1'b1, 1'b0);
        drain_check("R6 relu off", 1'b0, 1'b0);

        // R7: accumulate, clear and drain during read-out are ignored
        p_size = 5'd6; set_perms(6, 1'b0);
        for (int c = 0; c < 6; c++) push(c, c == 0, -3000, 3000);
        drain_check("R7 disturbed", 1'b0, 1'b1);
        drain_check("R7 after", 1'b0, 1'b0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule